// File: doc/BRIEF.md
# Iterative Integer Multiply Unit

This block performs the four 32-bit integer multiply operations of a RISC-V core. A request carries the 32-bit instruction word and the two source operand values. The unit decodes the instruction word. It sign-extends or zero-extends each operand independently, as the function code asks. It forms the full 64-bit product and returns either the low half or the high half.

Internally the product is built from operand magnitudes. A configurable number of multiplier bits is retired per clock. The sign of the result is applied once at the end. A request is taken with a valid/ready handshake while the unit is idle. The result appears later as a one-cycle valid pulse, together with a write enable and the destination register index.

The write enable is held low in two cases. The first is when the instruction word is not a qualified multiply. The second is when the destination is register zero. The register file can therefore use the response directly.

Top module: `imul_unit`

## Requirements
- R1: `rsp_wen` can be high only when the request's instruction word had bits [31:25] = 0000001, bits [6:0] = 0110011 and bit 14 = 0. For any other word the response still arrives with `rsp_wen` low, and `rsp_data` is still formed from bits [13:12].
- R2: Function code 000 in bits [14:12] returns the low 32 bits of the operand product.
- R3: Function code 001 returns bits [63:32] of the product, with both operands sign-extended.
- R4: Function code 010 returns bits [63:32] of the product, with `req_a` sign-extended and `req_b` zero-extended.
- R5: Function code 011 returns bits [63:32] of the product, with both operands zero-extended.
- R6: `rsp_rd` repeats bits [11:7] of the accepted word. When that index is 0, `rsp_wen` stays low.
- R7: `req_ready` is high only while the unit is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_valid` is ignored while the unit is busy: no extra response appears and the pending result is unchanged.
- R8: `rsp_valid` is high for exactly one cycle. The pulse comes 32/DIGIT clock edges after the accepting edge, which is 8 edges by default. `req_ready` rises on the following edge.
- R9: After reset, `req_ready` is 1 and `rsp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Unit idle, request can be taken |
| req_instr | input | 32 | Instruction word of the request |
| req_a | input | 32 | First source operand |
| req_b | input | 32 | Second source operand |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_wen | output | 1 | Register write enable for the result |
| rsp_rd | output | 5 | Destination register index |
| rsp_data | output | 32 | Selected product half |

## Verification
The assertions assume that the requester keeps to the handshake. They also assume that `rst_n` is low for at least one clock edge before use. They do not assume that `req_valid` is low while the unit is busy. The stimulus deliberately offers unrelated requests during busy cycles, and the model accepts a request only on an edge where it sees ready high. Operands include 0, 1, 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF in every combination under each function code. Instruction words with a wrong top field, a wrong opcode or a divide-class function code are also applied.

// File: rtl/imul_pkg.sv
package imul_pkg;

    localparam logic [6:0] OPC_REG_REG = 7'b0110011;
    localparam logic [6:0] F7_MULDIV   = 7'b0000001;

    typedef enum logic [1:0] {
        K_LOW  = 2'd0,
        K_HISS = 2'd1,
        K_HISU = 2'd2,
        K_HIUU = 2'd3
    } mul_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } mul_state_e;

    typedef struct packed {
        logic       sign_a;
        logic       sign_b;
        logic       take_hi;
        logic       wen;
        logic [4:0] rd;
    } mul_ctl_t;

endpackage

// File: rtl/imul_decode.sv
module imul_decode
    import imul_pkg::*;
(
    input  logic [31:0] instr,
    output mul_ctl_t    ctl
);
    mul_kind_e kind;
    logic      legal;

    always_comb begin
        kind  = mul_kind_e'(instr[13:12]);
        legal = (instr[31:25] == F7_MULDIV) && (instr[6:0] == OPC_REG_REG) && !instr[14];
        ctl.rd      = instr[11:7];
        ctl.wen     = legal && (instr[11:7] != 5'd0);
        ctl.take_hi = (kind != K_LOW);
        ctl.sign_a  = (kind == K_HISS) || (kind == K_HISU);
        ctl.sign_b  = (kind == K_HISS);
    end
endmodule

// File: rtl/imul_operand.sv
module imul_operand #(
    parameter int W = 32
) (
    input  logic [W-1:0] value,
    input  logic         signed_op,
    output logic [W-1:0] mag,
    output logic         neg
);
    always_comb begin
        neg = signed_op && value[W-1];
        mag = neg ? (~value + 1'b1) : value;
    end
endmodule

// File: rtl/imul_stepper.sv
module imul_stepper #(
    parameter int W     = 32,
    parameter int DIGIT = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic           step,
    input  logic [W-1:0]   a_mag,
    input  logic [W-1:0]   b_mag,
    output logic [2*W-1:0] prod
);
    localparam int SW = W + DIGIT;

    logic [W-1:0]   mcand_q, mcand_d;
    logic [2*W-1:0] prod_q,  prod_d;
    logic [SW-1:0]  terms [DIGIT];
    logic [SW-1:0]  partial;
    logic [SW-1:0]  sum;

    for (genvar j = 0; j < DIGIT; j++) begin : g_term
        assign terms[j] = prod_q[j] ? ({{DIGIT{1'b0}}, mcand_q} << j) : '0;
    end

    always_comb begin
        partial = '0;
        for (int j = 0; j < DIGIT; j++) begin
            partial = partial + terms[j];
        end
        sum     = {{DIGIT{1'b0}}, prod_q[2*W-1:W]} + partial;
        mcand_d = mcand_q;
        prod_d  = prod_q;
        if (load) begin
            mcand_d = a_mag;
            prod_d  = {{W{1'b0}}, b_mag};
        end else if (step) begin
            prod_d = {sum, prod_q[W-1:DIGIT]};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mcand_q <= '0;
            prod_q  <= '0;
        end else begin
            mcand_q <= mcand_d;
            prod_q  <= prod_d;
        end
    end

    assign prod = prod_q;

    a_r7_no_load_while_stepping: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && step));
endmodule

// File: rtl/imul_unit.sv
module imul_unit
    import imul_pkg::*;
#(
    parameter int XW    = 32,
    parameter int DIGIT = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [31:0]   req_instr,
    input  logic [XW-1:0] req_a,
    input  logic [XW-1:0] req_b,
    output logic          rsp_valid,
    output logic          rsp_wen,
    output logic [4:0]    rsp_rd,
    output logic [XW-1:0] rsp_data
);
    localparam int STEPS = XW / DIGIT;
    localparam int CW    = (STEPS > 1) ? $clog2(STEPS) : 1;
    localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

    typedef struct packed {
        mul_state_e  st;
        logic [CW-1:0] cnt;
        logic        neg;
        mul_ctl_t    ctl;
    } unit_regs_t;

    unit_regs_t     r_q, r_d;
    mul_ctl_t       dec_ctl;
    logic [XW-1:0]  a_mag, b_mag;
    logic           a_neg, b_neg;
    logic           load, step;
    logic [2*XW-1:0] prod, full;

    imul_decode u_dec (.instr(req_instr), .ctl(dec_ctl));

    imul_operand #(.W(XW)) u_opa (.value(req_a), .signed_op(dec_ctl.sign_a), .mag(a_mag), .neg(a_neg));
    imul_operand #(.W(XW)) u_opb (.value(req_b), .signed_op(dec_ctl.sign_b), .mag(b_mag), .neg(b_neg));

    imul_stepper #(.W(XW), .DIGIT(DIGIT)) u_step (
        .clk(clk), .rst_n(rst_n), .load(load), .step(step),
        .a_mag(a_mag), .b_mag(b_mag), .prod(prod)
    );

    always_comb begin
        r_d  = r_q;
        load = 1'b0;
        step = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    load    = 1'b1;
                    r_d.st  = ST_RUN;
                    r_d.cnt = '0;
                    r_d.neg = a_neg ^ b_neg;
                    r_d.ctl = dec_ctl;
                end
            end
            ST_RUN: begin
                step = 1'b1;
                if (r_q.cnt == LAST) r_d.st = ST_DONE;
                else                 r_d.cnt = r_q.cnt + 1'b1;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st  <= ST_IDLE;
            r_q.cnt <= '0;
            r_q.neg <= 1'b0;
            r_q.ctl <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        full      = r_q.neg ? (~prod + 1'b1) : prod;
        req_ready = (r_q.st == ST_IDLE);
        rsp_valid = (r_q.st == ST_DONE);
        rsp_wen   = rsp_valid && r_q.ctl.wen;
        rsp_rd    = r_q.ctl.rd;
        rsp_data  = r_q.ctl.take_hi ? full[2*XW-1:XW] : full[XW-1:0];
    end

    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    a_r7_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!req_ready && !rsp_valid));
    a_r7_not_ready_with_result: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);
    a_r6_no_write_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_wen |-> (rsp_valid && rsp_rd != 5'd0));
    a_r8_ready_after_result: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> req_ready);
endmodule

// File: tb/imul_unit_test.sv
module imul_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam int DIGIT      = 4;
    localparam int STEPS      = 32 / DIGIT;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic        req_ready;
    logic [31:0] req_instr, req_a, req_b;
    logic        rsp_valid, rsp_wen;
    logic [4:0]  rsp_rd;
    logic [31:0] rsp_data;

    int checks = 0;
    int fails  = 0;
    int cycle  = 0;
    int free_at = 0;

    typedef struct {
        int          due;
        logic [31:0] data;
        logic        wen;
        logic [4:0]  rd;
        logic [2:0]  f3;
    } exp_t;
    exp_t pend[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    imul_unit #(.XW(32), .DIGIT(DIGIT)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_instr(req_instr), .req_a(req_a), .req_b(req_b),
        .rsp_valid(rsp_valid), .rsp_wen(rsp_wen), .rsp_rd(rsp_rd), .rsp_data(rsp_data)
    );

    function automatic logic [31:0] ref_data(logic [31:0] ins, logic [31:0] a, logic [31:0] b);
        logic [63:0] ea, eb, p;
        ea = {32'b0, a};
        eb = {32'b0, b};
        if (ins[13:12] == 2'd1 || ins[13:12] == 2'd2) ea = {{32{a[31]}}, a};
        if (ins[13:12] == 2'd1) eb = {{32{b[31]}}, b};
        p = ea * eb;
        return (ins[13:12] == 2'd0) ? p[31:0] : p[63:32];
    endfunction

    function automatic logic [31:0] mk(logic [6:0] f7, logic [2:0] f3, logic [4:0] rd, logic [6:0] opc);
        return {f7, 5'd7, 5'd9, f3, rd, opc};
    endfunction

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cycle);
        end
    endtask

    // reference model: records accepted requests and their due cycle
    always @(posedge clk) begin
        if (rst_n) begin
            cycle = cycle + 1;
            if (req_valid && req_ready) begin
                exp_t e;
                e.due  = cycle + STEPS;
                e.data = ref_data(req_instr, req_a, req_b);
                e.wen  = (req_instr[31:25] == 7'b0000001) && (req_instr[6:0] == 7'b0110011)
                         && !req_instr[14] && (req_instr[11:7] != 5'd0);
                e.rd   = req_instr[11:7];
                e.f3   = req_instr[14:12];
                pend.push_back(e);
                free_at = cycle + STEPS + 1;
            end
        end
    end

    // per-cycle comparison
    always @(negedge clk) begin
        if (rst_n) begin
            bit exp_v;
            exp_v = (pend.size() > 0) && (pend[0].due == cycle);
            check(req_ready == (cycle >= free_at), "R7 ready", 32'(req_ready), 32'(cycle >= free_at));
            if (exp_v || rsp_valid) begin
                check(rsp_valid == exp_v, "R8 valid timing", 32'(rsp_valid), 32'(exp_v));
                if (exp_v && rsp_valid) begin
                    exp_t e;
                    string tag;
                    e = pend.pop_front();
                    case (e.f3[1:0])
                        2'd0: tag = "R2 low product";
                        2'd1: tag = "R3 high signed";
                        2'd2: tag = "R4 high signed-unsigned";
                        default: tag = "R5 high unsigned";
                    endcase
                    check(rsp_data == e.data, tag, rsp_data, e.data);
                    check(rsp_wen == e.wen, (e.rd == 0) ? "R6 zero dest wen" : "R1 qualify wen",
                          32'(rsp_wen), 32'(e.wen));
                    check(rsp_rd == e.rd, "R6 rd", 32'(rsp_rd), 32'(e.rd));
                end
            end
        end
    end

    task automatic send(logic [31:0] ins, logic [31:0] a, logic [31:0] b, bit noise);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_instr = ins;
        req_a     = a;
        req_b     = b;
        @(negedge clk);
        if (noise) begin
            // R7: offers during busy must be ignored
            req_instr = mk(7'b0000001, 3'b011, 5'd31, 7'b0110011);
            req_a     = 32'hDEADBEEF;
            req_b     = 32'hFFFFFFFF;
            repeat (3) @(negedge clk);
        end
        req_valid = 1'b0;
    endtask

    logic [31:0] corner [6] = '{32'h0, 32'h1, 32'hFFFFFFFF, 32'h80000000, 32'h7FFFFFFF, 32'h12345678};

    initial begin
        rst_n     = 1'b0;
        req_valid = 1'b0;
        req_instr = '0;
        req_a     = '0;
        req_b     = '0;
        repeat (3) @(negedge clk);
        check(req_ready == 1'b1, "R9 reset ready", 32'(req_ready), 32'd1);
        check(rsp_valid == 1'b0, "R9 reset valid", 32'(rsp_valid), 32'd0);
        rst_n = 1'b1;

        // R2..R5 corner operand grid
        for (int f = 0; f < 4; f++)
            for (int i = 0; i < 6; i++)
                for (int j = 0; j < 6; j++)
                    send(mk(7'b0000001, 3'(f), 5'd5, 7'b0110011), corner[i], corner[j], 1'b0);

        // R6 destination zero
        for (int f = 0; f < 4; f++)
            send(mk(7'b0000001, 3'(f), 5'd0, 7'b0110011), 32'h80000000, 32'hFFFFFFFF, 1'b0);

        // R1 unqualified words
        send(mk(7'b0000000, 3'b001, 5'd3, 7'b0110011), 32'hFFFFFFFF, 32'h80000000, 1'b0);
        send(mk(7'b0100000, 3'b000, 5'd3, 7'b0110011), 32'h12345678, 32'h9ABCDEF0, 1'b0);
        send(mk(7'b0000001, 3'b011, 5'd3, 7'b0110111), 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b0);
        for (int f = 4; f < 8; f++)
            send(mk(7'b0000001, 3'(f), 5'd3, 7'b0110011), 32'h80000000, 32'h00000003, 1'b0);

        // R7 busy offers
        for (int k = 0; k < 8; k++)
            send(mk(7'b0000001, 3'(k % 4), 5'(k + 1), 7'b0110011), $urandom, $urandom, 1'b1);

        // mixed random traffic
        for (int k = 0; k < 300; k++)
            send(mk(7'b0000001, 3'($urandom % 4), 5'($urandom), 7'b0110011), $urandom, $urandom, 1'b0);

        repeat (STEPS + 3) @(negedge clk);
        check(pend.size() == 0, "R8 missing response", 32'(pend.size()), 32'd0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycle, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule